// File: doc/BRIEF.md
# Halt Wake and Peripheral Clock Gating Controller

This block holds the processor in a low-power halt state and decides when to release it. The core raises a one-cycle halt request. From the next clock the block reports halt as active and holds the program counter still. The system clock itself keeps running. The block watches a fixed set of wake and reset event lines, and the first qualifying event ends the halt. The cause of that exit is recorded in a status field that clears when it is read.

The block also holds two 8-bit power-down registers on a small register port. Setting a bit to 1 blocks the clock enable of one on-chip peripheral, and clearing it to 0 restores the enable. One bit of the second register switches the brown-out detector off. While that bit is set, brown-out events cannot reset the chip. The Ethernet MAC has no power-down bit, so its clock is never gated, and its receive interrupt can always wake the core.

Any reset event clears halt at the next clock edge. At the same edge it returns both power-down registers to their all-enabled value and raises the reset request output.

Top module: `halt_pwr_ctl`

## Requirements
- R1: After the block reset `rst_n` is released, `halted`, `rst_req` and `bo_det_off` are 0. Both power-down registers and the status field read 0, and `pclk_en` equals the peripheral mask (every peripheral enabled).
- R2: A `halt_req` seen in a cycle with no wake or reset event sets `halted` at the next edge. `pc_hold` is 1 in that request cycle and in every halted cycle. If a wake event is present in the request cycle, halt is not entered and `pc_hold` stays 0.
- R3: While halted, `nmi`, any bit of `irq` (no global enable exists) or `mac_rx_irq` clears `halted` at the next edge.
- R4: `wdt_timeout` has no effect unless `wdt_nmi_en` or `wdt_rst_en` is 1. With `wdt_nmi_en` it acts as a wake event. With `wdt_rst_en` it acts as a reset event.
- R5: A reset event is `ext_rst_n` low, `dbg_rst`, a qualified watchdog reset, or `bo_rst` while `bo_en` is 1 and the brown-out off bit is 0. At the next edge it sets `rst_req` to 1, clears `halted`, and clears both power-down registers. It takes priority over a write in the same cycle.
- R6: The first power-down register is at address 0 and uses mask 0xFF. The second is at address 1 and uses mask 0x8F. Bits outside a mask read 0 and ignore writes. `pclk_en[7:0]` follows the inverted first register and `pclk_en[11:8]` follows the inverted low four bits of the second, each one edge after the register changes. `pclk_en[15:12]` stays 0.
- R7: Bit 7 of the second register drives `bo_det_off`. While it is 1, `bo_rst` is ignored: no `rst_req` and no change to the registers.
- R8: The status field is at address 2. Its bits are: bit 0 NMI, bit 1 maskable interrupt, bit 2 MAC receive, bit 3 watchdog wake, bit 4 reset. An event sets its bit only if it occurs while halted. A cycle with `rd_en` at address 2 returns the current value and clears the field at the next edge, though a new capture in that same cycle is kept. Writes to address 2 are ignored, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, running in halt |
| rst_n | input | 1 | Block reset, asynchronous active low |
| halt_req | input | 1 | Halt request pulse from the core |
| nmi | input | 1 | Nonmaskable interrupt |
| irq | input | 4 | Maskable interrupt lines |
| mac_rx_irq | input | 1 | Ethernet MAC receive interrupt |
| wdt_timeout | input | 1 | Watchdog time-out event |
| wdt_nmi_en | input | 1 | Watchdog time-out routed as NMI |
| wdt_rst_en | input | 1 | Watchdog time-out routed as reset |
| ext_rst_n | input | 1 | External reset pin, active low, sampled |
| dbg_rst | input | 1 | Debug reset command |
| bo_rst | input | 1 | Brown-out reset event |
| bo_en | input | 1 | Brown-out reset configured on |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| halted | output | 1 | Halt active |
| pc_hold | output | 1 | Program counter advance inhibit |
| rst_req | output | 1 | Reset request |
| pclk_en | output | 16 | Per-peripheral registered clock enables |
| bo_det_off | output | 1 | Brown-out detector disable |

## Verification
A behavioural reference model is compared with the design on every clock. The stimulus sends each wake source on its own so that a wrong cause bit shows up. It pulses the watchdog under every routing setting, which separates an ignored time-out from a wake and from a reset. It applies each reset source, while halted and while running, to show that reset wins over writes and over wake. Register writes with all-ones data reveal the masks. Writes checked in the next cycle reveal the one-edge lag of the clock enables. A brown-out event is applied with the detector-off bit set and with it clear, which shows whether the event is gated.

// File: rtl/halt_pwr_pkg.sv
package halt_pwr_pkg;
  typedef struct packed {
    logic rst;
    logic wdt;
    logic mac;
    logic irq;
    logic nmi;
  } wake_cause_t;

  localparam int CAUSE_W = $bits(wake_cause_t);

  localparam logic [1:0] ADDR_PD1  = 2'd0;
  localparam logic [1:0] ADDR_PD2  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hp_wake_ctl.sv
module hp_wake_ctl
  import halt_pwr_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               nmi,
  input  logic [NIRQ-1:0]    irq,
  input  logic               mac_rx_irq,
  input  logic               wdt_timeout,
  input  logic               wdt_nmi_en,
  input  logic               wdt_rst_en,
  input  logic               ext_rst_n,
  input  logic               dbg_rst,
  input  logic               bo_rst,
  input  logic               bo_en,
  input  logic               bo_off,
  output logic               halted,
  output logic               pc_hold,
  output logic               rst_req,
  output logic               rst_ev,
  output logic [CAUSE_W-1:0] cause
);
  logic        halted_q, halted_d;
  logic        rst_req_q;
  logic        wdt_wake, wdt_rst, bo_live, any_wake, enter;
  wake_cause_t cause_s;

  always_comb begin
    wdt_wake = wdt_timeout & wdt_nmi_en;
    wdt_rst  = wdt_timeout & wdt_rst_en;
    bo_live  = bo_rst & bo_en & ~bo_off;
    rst_ev   = ~ext_rst_n | dbg_rst | bo_live | wdt_rst;
    any_wake = nmi | (|irq) | mac_rx_irq | wdt_wake;
    enter    = halt_req & ~any_wake & ~rst_ev;

    if (rst_ev) begin
      halted_d = 1'b0;
    end else if (halted_q) begin
      halted_d = ~any_wake;
    end else begin
      halted_d = enter;
    end

    cause_s.rst = halted_q & rst_ev;
    cause_s.wdt = halted_q & wdt_wake;
    cause_s.mac = halted_q & mac_rx_irq;
    cause_s.irq = halted_q & (|irq);
    cause_s.nmi = halted_q & nmi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q  <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      halted_q  <= halted_d;
      rst_req_q <= rst_ev;
    end
  end

  assign halted  = halted_q;
  assign pc_hold = halted_q | enter;
  assign rst_req = rst_req_q;
  assign cause   = cause_s;
endmodule

// File: rtl/hp_pd_regs.sv
module hp_pd_regs
  import halt_pwr_pkg::*;
#(
  parameter int              DW       = 8,
  parameter logic [DW-1:0]   PD1_MASK = 8'hFF,
  parameter logic [DW-1:0]   PD2_MASK = 8'h8F,
  parameter int              VBO_BIT  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      wdata,
  input  logic               rst_ev,
  input  logic [CAUSE_W-1:0] cause,
  output logic [DW-1:0]      rdata,
  output logic [DW-1:0]      pd1_q,
  output logic [DW-1:0]      pd2_q,
  output logic               bo_off
);
  logic [DW-1:0]      pd1_d, pd2_d;
  logic [CAUSE_W-1:0] stat_q, stat_d;
  logic               rd_stat;

  always_comb begin
    pd1_d = pd1_q;
    pd2_d = pd2_q;
    if (rst_ev) begin
      pd1_d = '0;
      pd2_d = '0;
    end else if (wr_en) begin
      if (addr == ADDR_PD1) pd1_d = wdata & PD1_MASK;
      if (addr == ADDR_PD2) pd2_d = wdata & PD2_MASK;
    end
    rd_stat = rd_en && (addr == ADDR_STAT);
    stat_d  = (rd_stat ? '0 : stat_q) | cause;
  end

  always_comb begin
    case (addr)
      ADDR_PD1:  rdata = pd1_q;
      ADDR_PD2:  rdata = pd2_q;
      ADDR_STAT: rdata = DW'(stat_q);
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd1_q  <= '0;
      pd2_q  <= '0;
      stat_q <= '0;
    end else begin
      pd1_q  <= pd1_d;
      pd2_q  <= pd2_d;
      stat_q <= stat_d;
    end
  end

  assign bo_off = pd2_q[VBO_BIT];
endmodule

// File: rtl/hp_clk_en.sv
module hp_clk_en (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_bit,
  output logic en_q
);
  logic en_d;

  always_comb begin
    en_d = ~pd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
    end else begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/halt_pwr_ctl.sv
module halt_pwr_ctl
  import halt_pwr_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            NIRQ     = 4,
  parameter logic [DW-1:0] PD1_MASK = 8'hFF,
  parameter logic [DW-1:0] PD2_MASK = 8'h8F,
  parameter int            VBO_BIT  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            nmi,
  input  logic [NIRQ-1:0] irq,
  input  logic            mac_rx_irq,
  input  logic            wdt_timeout,
  input  logic            wdt_nmi_en,
  input  logic            wdt_rst_en,
  input  logic            ext_rst_n,
  input  logic            dbg_rst,
  input  logic            bo_rst,
  input  logic            bo_en,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            halted,
  output logic            pc_hold,
  output logic            rst_req,
  output logic [2*DW-1:0] pclk_en,
  output logic            bo_det_off
);
  localparam int            PW      = 2 * DW;
  localparam logic [DW-1:0] VBO_ONE = DW'(1) << VBO_BIT;
  localparam logic [PW-1:0] PMASK   = {PD2_MASK & ~VBO_ONE, PD1_MASK};

  logic               rst_int_n;
  logic               rst_ev;
  logic               bo_off;
  logic [CAUSE_W-1:0] cause;
  logic [DW-1:0]      pd1_q, pd2_q;
  logic [PW-1:0]      pd_all, en_raw;

  hp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  hp_wake_ctl #(.NIRQ(NIRQ)) u_wake (
    .clk(clk), .rst_n(rst_int_n), .halt_req(halt_req), .nmi(nmi), .irq(irq),
    .mac_rx_irq(mac_rx_irq), .wdt_timeout(wdt_timeout), .wdt_nmi_en(wdt_nmi_en),
    .wdt_rst_en(wdt_rst_en), .ext_rst_n(ext_rst_n), .dbg_rst(dbg_rst),
    .bo_rst(bo_rst), .bo_en(bo_en), .bo_off(bo_off), .halted(halted),
    .pc_hold(pc_hold), .rst_req(rst_req), .rst_ev(rst_ev), .cause(cause)
  );

  hp_pd_regs #(.DW(DW), .PD1_MASK(PD1_MASK), .PD2_MASK(PD2_MASK), .VBO_BIT(VBO_BIT)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rst_ev(rst_ev), .cause(cause), .rdata(rdata),
    .pd1_q(pd1_q), .pd2_q(pd2_q), .bo_off(bo_off)
  );

  assign pd_all = {pd2_q, pd1_q};

  for (genvar i = 0; i < PW; i++) begin : g_gate
    hp_clk_en u_en (
      .clk(clk), .rst_n(rst_int_n), .pd_bit(pd_all[i]), .en_q(en_raw[i])
    );
  end

  assign pclk_en    = en_raw & PMASK;
  assign bo_det_off = bo_off;
endmodule

// File: rtl/halt_pwr_chk.sv
module halt_pwr_chk #(
  parameter int            DW    = 8,
  parameter int            NIRQ  = 4,
  parameter logic [2*DW-1:0] PMASK = '0
) (
  input logic            clk,
  input logic            rst_int_n,
  input logic            halt_req,
  input logic            nmi,
  input logic [NIRQ-1:0] irq,
  input logic            mac_rx_irq,
  input logic            wdt_timeout,
  input logic            wdt_nmi_en,
  input logic            wdt_rst_en,
  input logic            ext_rst_n,
  input logic            dbg_rst,
  input logic            bo_rst,
  input logic            bo_en,
  input logic            bo_det_off,
  input logic            halted,
  input logic            pc_hold,
  input logic            rst_req,
  input logic [2*DW-1:0] pclk_en,
  input logic [DW-1:0]   pd1_q,
  input logic [DW-1:0]   pd2_q
);
  logic other_rst, plain_wake;
  assign other_rst  = ~ext_rst_n | dbg_rst | (wdt_timeout & wdt_rst_en);
  assign plain_wake = nmi | (|irq) | mac_rx_irq;

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!halted && halt_req && !plain_wake && !wdt_timeout && !other_rst && !bo_rst) |=> halted);

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted |-> pc_hold);

  // R3
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (halted && plain_wake) |=> !halted);

  // R4
  wdt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (halted && wdt_timeout && !wdt_nmi_en && !wdt_rst_en && !plain_wake && !other_rst && !bo_rst)
      |=> (halted && !rst_req));

  // R5
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    other_rst |=> (rst_req && !halted && pd1_q == '0 && pd2_q == '0));

  // R6
  pclk_lag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (pclk_en == ($past(~{pd2_q, pd1_q}) & PMASK)));

  // R7
  bo_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bo_det_off && bo_rst && bo_en && !other_rst) |=> !rst_req);
endmodule

bind halt_pwr_ctl halt_pwr_chk #(.DW(DW), .NIRQ(NIRQ), .PMASK(PMASK)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .halt_req(halt_req), .nmi(nmi), .irq(irq),
  .mac_rx_irq(mac_rx_irq), .wdt_timeout(wdt_timeout), .wdt_nmi_en(wdt_nmi_en),
  .wdt_rst_en(wdt_rst_en), .ext_rst_n(ext_rst_n), .dbg_rst(dbg_rst),
  .bo_rst(bo_rst), .bo_en(bo_en), .bo_det_off(bo_det_off), .halted(halted),
  .pc_hold(pc_hold), .rst_req(rst_req), .pclk_en(pclk_en), .pd1_q(pd1_q),
  .pd2_q(pd2_q)
);

// File: tb/halt_pwr_ctl_test.sv
`timescale 1ns/1ps
module halt_pwr_ctl_test;
  localparam logic [7:0]  M1    = 8'hFF;
  localparam logic [7:0]  M2    = 8'h8F;
  localparam logic [15:0] PMASK = 16'h0FFF;

  logic clk = 1'b0;
  logic rst_n;
  logic halt_req, nmi, mac_rx_irq, wdt_timeout, wdt_nmi_en, wdt_rst_en;
  logic ext_rst_n, dbg_rst, bo_rst, bo_en, wr_en, rd_en;
  logic [3:0]  irq;
  logic [1:0]  addr;
  logic [7:0]  wdata, rdata;
  logic        halted, pc_hold, rst_req, bo_det_off;
  logic [15:0] pclk_en;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  halt_pwr_ctl uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .nmi(nmi), .irq(irq),
    .mac_rx_irq(mac_rx_irq), .wdt_timeout(wdt_timeout), .wdt_nmi_en(wdt_nmi_en),
    .wdt_rst_en(wdt_rst_en), .ext_rst_n(ext_rst_n), .dbg_rst(dbg_rst),
    .bo_rst(bo_rst), .bo_en(bo_en), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .halted(halted), .pc_hold(pc_hold),
    .rst_req(rst_req), .pclk_en(pclk_en), .bo_det_off(bo_det_off)
  );

  // Reference model state
  bit       m_halted, m_rst_req;
  bit [7:0] m_pd1, m_pd2;
  bit [4:0] m_stat;
  bit [15:0] m_en;

  function automatic bit f_rst_ev();
    return !ext_rst_n || dbg_rst || (bo_rst && bo_en && !m_pd2[7]) ||
           (wdt_timeout && wdt_rst_en);
  endfunction

  function automatic bit f_wake();
    return nmi || (irq != 4'd0) || mac_rx_irq || (wdt_timeout && wdt_nmi_en);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halted = 0; m_rst_req = 0; m_pd1 = 0; m_pd2 = 0; m_stat = 0; m_en = PMASK;
    end else begin
      bit rv, wk;
      bit [4:0] cap;
      rv = f_rst_ev();
      wk = f_wake();
      cap = 0;
      if (m_halted) cap = {rv, wdt_timeout && wdt_nmi_en, mac_rx_irq, irq != 4'd0, nmi};
      if (rd_en && addr == 2'd2) m_stat = 0;
      m_stat = m_stat | cap;
      m_en = ~{m_pd2, m_pd1} & PMASK;
      if (rv) begin
        m_pd1 = 0; m_pd2 = 0;
      end else if (wr_en) begin
        if (addr == 2'd0) m_pd1 = wdata & M1;
        if (addr == 2'd1) m_pd2 = wdata & M2;
      end
      m_rst_req = rv;
      if (rv) m_halted = 0;
      else if (m_halted) m_halted = !wk;
      else m_halted = halt_req && !wk;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit [7:0] er;
      bit eph;
      eph = m_halted || (halt_req && !f_wake() && !f_rst_ev());
      case (addr)
        2'd0: er = m_pd1;
        2'd1: er = m_pd2;
        2'd2: er = {3'b0, m_stat};
        default: er = 8'h00;
      endcase
      chk(halted == m_halted, "R2 halted", halted, m_halted);
      chk(pc_hold == eph, "R2 pc_hold", pc_hold, eph);
      chk(rst_req == m_rst_req, "R5 rst_req", rst_req, m_rst_req);
      chk(pclk_en == m_en, "R6 pclk_en", pclk_en, m_en);
      chk(bo_det_off == m_pd2[7], "R7 bo_det_off", bo_det_off, m_pd2[7]);
      chk(rdata == er, "R8 rdata", rdata, er);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    halt_req = 0; nmi = 0; irq = 0; mac_rx_irq = 0; wdt_timeout = 0;
    ext_rst_n = 1; dbg_rst = 0; bo_rst = 0; wr_en = 0; rd_en = 0; wdata = 0;
  endtask

  task automatic enter_halt();
    halt_req = 1; tick(); halt_req = 0;
    chk(halted == 1'b1, "R2 enter", halted, 1);
  endtask

  task automatic write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic read_stat(input logic [4:0] exp, input string tag);
    addr = 2'd2; rd_en = 1; #1;
    chk(rdata == {3'b0, exp}, tag, rdata, exp);
    tick(); rd_en = 0; #1;
    chk(rdata == 8'h00, "R8 clear on read", rdata, 0);
  endtask

  initial begin
    rst_n = 0; idle(); wdt_nmi_en = 0; wdt_rst_en = 0; bo_en = 0; addr = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk(halted == 0 && rst_req == 0, "R1 halted/rst_req", {halted, rst_req}, 0);
    chk(pclk_en == PMASK, "R1 pclk_en", pclk_en, PMASK);
    chk(bo_det_off == 0, "R1 bo_det_off", bo_det_off, 0);
    addr = 2'd0; #1; chk(rdata == 0, "R1 pd1", rdata, 0);
    addr = 2'd1; #1; chk(rdata == 0, "R1 pd2", rdata, 0);
    addr = 2'd2; #1; chk(rdata == 0, "R1 stat", rdata, 0);

    // R2 entry with pc_hold in request cycle
    halt_req = 1; #1;
    chk(pc_hold == 1, "R2 pc_hold req cycle", pc_hold, 1);
    tick(); halt_req = 0;
    chk(halted == 1, "R2 enter", halted, 1);
    repeat (3) tick();
    chk(halted == 1 && pc_hold == 1, "R2 stays halted", {halted, pc_hold}, 3);

    // R3 wake by nmi, irq, mac
    nmi = 1; tick(); nmi = 0;
    chk(halted == 0, "R3 nmi wake", halted, 0);
    read_stat(5'h01, "R8 nmi cause");
    enter_halt();
    irq = 4'b0100; tick(); irq = 0;
    chk(halted == 0, "R3 irq wake", halted, 0);
    read_stat(5'h02, "R8 irq cause");
    enter_halt();
    mac_rx_irq = 1; tick(); mac_rx_irq = 0;
    chk(halted == 0, "R3 mac wake", halted, 0);
    read_stat(5'h04, "R8 mac cause");

    // R2 halt request with concurrent wake
    halt_req = 1; nmi = 1; #1;
    chk(pc_hold == 0, "R2 pc_hold with wake", pc_hold, 0);
    tick(); halt_req = 0; nmi = 0;
    chk(halted == 0, "R2 no entry with wake", halted, 0);
    // R8 wake outside halt not captured
    addr = 2'd2; #1; chk(rdata == 0, "R8 no capture when running", rdata, 0);

    // R4 watchdog routing
    enter_halt();
    wdt_timeout = 1; tick(); wdt_timeout = 0;
    chk(halted == 1 && rst_req == 0, "R4 wdt ignored", {halted, rst_req}, 2);
    wdt_nmi_en = 1; wdt_timeout = 1; tick(); wdt_timeout = 0;
    chk(halted == 0 && rst_req == 0, "R4 wdt nmi wake", {halted, rst_req}, 0);
    read_stat(5'h08, "R8 wdt cause");
    wdt_nmi_en = 0; wdt_rst_en = 1;
    write(2'd0, 8'h3C);
    enter_halt();
    wdt_timeout = 1; tick(); wdt_timeout = 0;
    chk(halted == 0 && rst_req == 1, "R4 wdt reset", {halted, rst_req}, 1);
    addr = 2'd0; #1; chk(rdata == 0, "R5 pd1 cleared by wdt", rdata, 0);
    read_stat(5'h10, "R8 reset cause");
    wdt_rst_en = 0;

    // R6 masks and enable lag
    write(2'd0, 8'hA5);
    chk(pclk_en == PMASK, "R6 enable lag", pclk_en, PMASK);
    write(2'd1, 8'hFF);
    addr = 2'd0; #1; chk(rdata == 8'hA5, "R6 pd1 readback", rdata, 8'hA5);
    addr = 2'd1; #1; chk(rdata == 8'h8F, "R6 pd2 mask", rdata, 8'h8F);
    tick();
    chk(pclk_en == 16'h005A, "R6 pclk_en gated", pclk_en, 16'h005A);
    write(2'd2, 8'hFF);
    addr = 2'd2; #1; chk(rdata == 0, "R8 status write ignored", rdata, 0);
    addr = 2'd3; #1; chk(rdata == 0, "R8 addr3 zero", rdata, 0);

    // R7 brown-out disabled by register bit
    chk(bo_det_off == 1, "R7 bo_det_off set", bo_det_off, 1);
    bo_en = 1; bo_rst = 1; tick(); bo_rst = 0;
    chk(rst_req == 0, "R7 bo ignored", rst_req, 0);
    addr = 2'd0; #1; chk(rdata == 8'hA5, "R7 regs kept", rdata, 8'hA5);
    tick();
    write(2'd1, 8'h03);
    chk(bo_det_off == 0, "R7 bo_det_off clear", bo_det_off, 0);
    enter_halt();
    bo_rst = 1; tick(); bo_rst = 0;
    chk(rst_req == 1 && halted == 0, "R5 bo reset", {rst_req, halted}, 2);
    addr = 2'd1; #1; chk(rdata == 0, "R5 pd2 cleared", rdata, 0);
    read_stat(5'h10, "R8 bo reset cause");
    bo_en = 0; bo_rst = 1; tick(); bo_rst = 0;
    chk(rst_req == 0, "R5 bo without enable", rst_req, 0);

    // R5 external pin and debug reset, priority over write
    write(2'd0, 8'hFF);
    enter_halt();
    ext_rst_n = 0; addr = 2'd0; wdata = 8'h11; wr_en = 1; tick();
    ext_rst_n = 1; wr_en = 0;
    chk(rst_req == 1 && halted == 0, "R5 ext pin", {rst_req, halted}, 2);
    addr = 2'd0; #1; chk(rdata == 0, "R5 reset beats write", rdata, 0);
    tick();
    dbg_rst = 1; tick(); dbg_rst = 0;
    chk(rst_req == 1 && halted == 0, "R5 debug reset", {rst_req, halted}, 2);
    tick();
    chk(rst_req == 0, "R5 rst_req drops", rst_req, 0);
    repeat (3) tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule